// File: doc/BRIEF.md
# Zero-Cross Delayed Gate Pulser

This block produces the drive for an open-drain power-switch gate from a fast system clock. It watches an already synchronised level from the mains zero-crossing detector and treats every change of that level, rising or falling, as the start of a new mains half-cycle. In AC mode, while the load is enabled, it waits a fixed number of clock cycles after each crossing and then pulls the active-low gate output low for a short, fixed number of cycles. The result is one narrow firing pulse per half-cycle, always at the same phase.

In DC mode the output ignores the mains input and stays low for as long as the load enable is high, which suits a relay coil. Both the delay and the pulse width are parameters counted in system-clock cycles, so a 1 MHz clock with the defaults gives a 1.2 ms delay and a 30 µs pulse. Because every pulse is timed from the same sampled edge, successive half-cycles get exactly the same delay. The analog crossing detector and the clock source are outside this block.

Top module: `zc_gate_pulser`

## Requirements
- R1: In AC mode (`dc_mode`=0) with `load_en`=1, each change of `zc_level`, rising or falling, yields exactly one low pulse on `gate_n`.
- R2: If a `zc_level` change is first seen at rising clock edge k, `gate_n` goes low right after edge k+`DELAY_CYC`.
- R3: An AC pulse that no new crossing cuts short keeps `gate_n` low for exactly `WIDTH_CYC` clock cycles. No AC pulse is ever longer than that.
- R4: With `load_en`=0 a crossing starts no pulse. If `load_en` falls while the delay is still running, that pulse is cancelled.
- R5: If `load_en` falls while `gate_n` is already low, the pulse still runs its full `WIDTH_CYC` cycles, and no later pulse starts.
- R6: A crossing that arrives while the delay is still running restarts the delay, counted from the new crossing.
- R7: A crossing (with `load_en`=1) that arrives during a pulse ends the pulse at once and starts a new delay.
- R8: In DC mode `gate_n` equals the inverse of `load_en`, and `zc_level` changes have no effect. Switching back to AC mode does not create a crossing by itself.
- R9: After reset `gate_n` is high. The first sample of `zc_level` after reset is taken as the reference level, not as a crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_level | input | 1 | Synchronised zero-cross detect level; each toggle marks a crossing |
| dc_mode | input | 1 | 1 = continuous relay drive, 0 = per-half-cycle gate pulses |
| load_en | input | 1 | Load enable |
| gate_n | output | 1 | Active-low gate/relay drive (0 = sink current) |

## Verification
On every cycle the assertions check four things. Each AC pulse begins exactly `DELAY_CYC` cycles after the most recent crossing. Each pulse begins only when the load is enabled. No pulse is longer than `WIDTH_CYC` cycles, and a pulse that ends without being cut has exactly that width. The DC-mode output holds steady while the enable holds. The bench scenarios cover what only ordered stimulus can show: that both crossing polarities fire, that a crossing is ignored while the load is disabled, that the delay restarts and a pulse is cut short by early crossings, that a pulse survives an enable drop, and that the DC mode ignores the mains input.

// File: rtl/zc_gate_pulser.sv
module zc_gate_pulser #(
  parameter int DELAY_CYC = 1200,
  parameter int WIDTH_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_level,
  input  logic dc_mode,
  input  logic load_en,
  output logic gate_n
);
  localparam int CMAX = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PULSE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          zc_q, primed;
  logic          zc_edge;

  assign zc_edge = primed & (zc_level ^ zc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q   <= 1'b0;
      primed <= 1'b0;
    end else begin
      zc_q   <= zc_level;
      primed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (dc_mode) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (zc_edge && load_en) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        S_WAIT:
          if (!load_en) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else if (cnt == CW'(DELAY_CYC - 1)) begin
            state <= S_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_PULSE:
          if (cnt == CW'(WIDTH_CYC - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: cnt <= '0;
      endcase
    end
  end

  assign gate_n = dc_mode ? ~load_en : (state != S_PULSE);

  // Observers for the assertions
  localparam int SAT = DELAY_CYC + 1;
  localparam int SW  = $clog2(SAT + 1);
  localparam int RW  = $clog2(WIDTH_CYC + 2);

  logic [SW-1:0] since_zc;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_zc <= SW'(SAT);
      low_run  <= '0;
    end else begin
      if (zc_edge) since_zc <= '0;
      else if (since_zc != SW'(SAT)) since_zc <= since_zc + 1'b1;
      if (!dc_mode && !gate_n) begin
        if (low_run != {RW{1'b1}}) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
      end
    end
  end

  p_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_n) && !dc_mode && $past(!dc_mode)) |-> since_zc == SW'(DELAY_CYC));

  p_start_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_n) && !dc_mode && $past(!dc_mode)) |-> $past(load_en));

  p_max_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dc_mode |-> low_run <= RW'(WIDTH_CYC));

  p_full_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_n) && !dc_mode && $past(!dc_mode) && !$past(zc_edge && load_en))
      |-> low_run == RW'(WIDTH_CYC));

  p_dc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_mode && $past(dc_mode) && $stable(load_en)) |-> $stable(gate_n));

endmodule

// File: tb/zc_gate_pulser_bench.sv
module zc_gate_pulser_bench;
  localparam int D   = 20;
  localparam int W   = 5;
  localparam int LIM = 3 * D + W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_level = 1'b0;
  logic dc_mode = 1'b0;
  logic load_en = 1'b0;
  logic gate_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  zc_gate_pulser #(.DELAY_CYC(D), .WIDTH_CYC(W)) u_zc_gate_pulser (
    .clk(clk), .rst_n(rst_n), .zc_level(zc_level),
    .dc_mode(dc_mode), .load_en(load_en), .gate_n(gate_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Toggles zc at a negedge, then scans LIM negedges. Index n counts negedges
  // after the toggle. drop_at clears load_en; cut_at toggles zc again.
  task automatic measure(input int drop_at, input int cut_at,
                         output int first, output int width, output int second);
    bit in_run = 0;
    bit run_done = 0;
    first = 0; width = 0; second = 0;
    zc_level = ~zc_level;
    for (int n = 1; n <= LIM; n++) begin
      @(negedge clk);
      if (!gate_n) begin
        if (first == 0) begin first = n; in_run = 1; end
        else if (run_done && second == 0) second = n;
        if (in_run) width++;
      end else if (in_run) begin
        in_run = 0; run_done = 1;
      end
      if (n == drop_at) load_en = 1'b0;
      if (n == cut_at) zc_level = ~zc_level;
    end
  endtask

  task automatic t_reset;
    check("R9 gate high in reset", gate_n, 1);
    @(negedge clk); rst_n = 1'b1;
    zc_level = 1'b1;
    load_en = 1'b1;
    for (int n = 0; n < LIM; n++) begin
      @(negedge clk);
      if (!gate_n) begin check("R9 first sample not a crossing", gate_n, 1); break; end
    end
    check("R9 gate high after reset", gate_n, 1);
  endtask

  task automatic t_both_edges;
    int f, w, s;
    measure(0, 0, f, w, s);
    check("R1 falling crossing fires", f != 0, 1);
    check("R2 delay after falling crossing", f, D + 1);
    check("R3 width after falling crossing", w, W);
    check("R1 single pulse per half-cycle", s, 0);
    measure(0, 0, f, w, s);
    check("R2 delay after rising crossing", f, D + 1);
    check("R3 width after rising crossing", w, W);
  endtask

  task automatic t_disabled;
    int f, w, s;
    load_en = 1'b0;
    measure(0, 0, f, w, s);
    check("R4 no pulse while disabled", f, 0);
    load_en = 1'b1;
    measure(5, 0, f, w, s);
    check("R4 drop during delay cancels", f, 0);
    load_en = 1'b1;
  endtask

  task automatic t_drop_in_pulse;
    int f, w, s;
    measure(D + 2, 0, f, w, s);
    check("R5 pulse starts on time", f, D + 1);
    check("R5 pulse completes after drop", w, W);
    load_en = 1'b1;
  endtask

  task automatic t_restart_wait;
    int f, w, s;
    measure(0, 10, f, w, s);
    check("R6 delay restarts from new crossing", f, 10 + D + 1);
    check("R6 width after restart", w, W);
    check("R6 no pulse from first crossing", s, 0);
  endtask

  task automatic t_cut_pulse;
    int f, w, s;
    measure(0, D + 3, f, w, s);
    check("R7 first pulse start", f, D + 1);
    check("R7 pulse cut by crossing", w, 3);
    check("R7 new delay from cutting crossing", s, D + 3 + D + 1);
  endtask

  task automatic t_dc;
    int f, w, s;
    dc_mode = 1'b1; load_en = 1'b1;
    @(negedge clk);
    check("R8 dc on with enable", gate_n, 0);
    load_en = 1'b0;
    @(negedge clk);
    check("R8 dc off without enable", gate_n, 1);
    measure(0, 0, f, w, s);
    check("R8 crossing ignored in dc mode", f, 0);
    load_en = 1'b1;
    @(negedge clk);
    check("R8 dc held low", gate_n, 0);
    dc_mode = 1'b0;
    for (int n = 0; n < LIM; n++) begin
      @(negedge clk);
      if (!gate_n) break;
    end
    check("R8 mode return is no crossing", gate_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_both_edges();
    t_disabled();
    t_drop_in_pulse();
    t_restart_wait();
    t_cut_pulse();
    t_dc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule